// File: doc/BRIEF.md
# Event Timestamp Word Generator

This block turns asynchronous input pulses into timestamp words for a downstream FIFO. A time counter runs freely in the system clock domain. The pulse input is brought into that domain by a short synchronizer chain, and only its rising edge counts. Each detected edge produces exactly one word. The low field of the word holds the time counter value and the top field holds a wrapping event sequence number. The word is pushed through a plain FIFO write port made of data, write-enable and full.

The sequence number advances on every detected event, including events whose word could not be written because the FIFO was full. A consumer that sees a jump in the sequence number can therefore tell exactly how many timestamps went missing. A sticky overflow flag also records that at least one word was dropped since the last reset.

Top module: `evts_stamp_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `fifoWrEn` and `overflow` are 0 and `fifoWrData` is 0.
- R2: Each rising edge of `pulseIn` yields at most one write, whatever the pulse width (one clock up to many clocks). `fifoWrEn` is never high in two consecutive cycles.
- R3: Word format: bits 31:24 carry the event sequence number and bits 23:0 carry the time value.
- R4: Number clock edges from 1 after reset release. The time counter then equals n after edge n. If `pulseIn` is first sampled high at edge n, `fifoWrEn` is high for the one cycle after edge n+2, and the time field equals n+1.
- R5: The sequence number starts at 0 after reset, rises by one per detected event, and wraps from 255 to 0.
- R6: The time counter is TIME_W bits wide (24 by default) and wraps modulo 2^TIME_W.
- R7: If `fifoFull` is high in the cycle the edge is detected (the cycle after edge n+1), no write happens for that event.
- R8: A dropped event sets `overflow`, which then stays at 1 until reset. The sequence number still advances, so the next written word shows the gap.
- R9: Reset applied during operation clears the time counter, the sequence number and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulseIn | input | 1 | Asynchronous event pulse |
| fifoWrData | output | 32 | Word to the FIFO: sequence number and time |
| fifoWrEn | output | 1 | One-cycle FIFO write strobe |
| fifoFull | input | 1 | FIFO cannot accept a word |
| overflow | output | 1 | Sticky flag: at least one word was dropped |

## Verification
The hardest situations to reach are the two wrap points. The sequence wrap needs more than 256 events. A time wrap at 24 bits needs over sixteen million cycles. The bench drives a long train of short pulses to cross the sequence wrap. It covers the time wrap with a second instance built with an 8-bit time field, fed from the same inputs and checked against the same cycle count. Drops are produced by raising `fifoFull` exactly over the edge-detect cycle, and the following word is checked for the skipped sequence value.

// File: rtl/evts_pkg.sv
package evts_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // event with room in FIFO: write word
    logic drop;     // event while FIFO full: discard word
  } evtsStrobe_t;
endpackage

// File: rtl/evts_sync.sv
module evts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= asyncIn;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/evts_ctrl.sv
module evts_ctrl
  import evts_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pulseIn,
  input  logic        fifoFull,
  output evtsStrobe_t stb
);
  logic syncLevel;
  logic prevLevel;
  logic edgeSeen;

  evts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (pulseIn),
    .syncOut (syncLevel)
  );

  always_ff @(posedge clk) begin
    if (rst) prevLevel <= 1'b0;
    else     prevLevel <= syncLevel;
  end

  assign edgeSeen = syncLevel & ~prevLevel;

  always_comb begin
    stb.capture = edgeSeen & ~fifoFull;
    stb.drop    = edgeSeen &  fifoFull;
  end
endmodule

// File: rtl/evts_datapath.sv
module evts_datapath
  import evts_pkg::*;
#(
  parameter int SEQ_W  = 8,
  parameter int TIME_W = 24,
  localparam int WORD_W = SEQ_W + TIME_W
) (
  input  logic              clk,
  input  logic              rst,
  input  evtsStrobe_t       stb,
  output logic [WORD_W-1:0] wrData,
  output logic              wrEn,
  output logic              ovfFlag
);
  logic [TIME_W-1:0] timeCnt;
  logic [SEQ_W-1:0]  seqCnt;

  always_ff @(posedge clk) begin
    if (rst) timeCnt <= '0;
    else     timeCnt <= timeCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         seqCnt <= '0;
    else if (stb.capture | stb.drop) seqCnt <= seqCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrData  <= '0;
      wrEn    <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      wrEn <= stb.capture;
      if (stb.capture) wrData  <= {seqCnt, timeCnt};
      if (stb.drop)    ovfFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/evts_stamp_top.sv
module evts_stamp_top
  import evts_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEQ_W       = 8,
  parameter int TIME_W      = 24,
  localparam int WORD_W     = SEQ_W + TIME_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulseIn,
  output logic [WORD_W-1:0] fifoWrData,
  output logic              fifoWrEn,
  input  logic              fifoFull,
  output logic              overflow
);
  evtsStrobe_t stb;

  evts_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pulseIn  (pulseIn),
    .fifoFull (fifoFull),
    .stb      (stb)
  );

  evts_datapath #(.SEQ_W(SEQ_W), .TIME_W(TIME_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrData  (fifoWrData),
    .wrEn    (fifoWrEn),
    .ovfFlag (overflow)
  );
endmodule

// File: rtl/evts_stamp_chk.sv
module evts_stamp_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pulseIn,
  input logic [WORD_W-1:0] fifoWrData,
  input logic              fifoWrEn,
  input logic              fifoFull,
  input logic              overflow
);
  // R2: an edge needs a low sample in between, so writes never abut
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    fifoWrEn |=> !fifoWrEn);

  // R7: a write never follows a cycle in which the FIFO was full
  a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    fifoWrEn |-> !$past(fifoFull));

  // R8: overflow is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8: overflow only rises after a cycle with the FIFO full
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(fifoFull));
endmodule

bind evts_stamp_top evts_stamp_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pulseIn    (pulseIn),
  .fifoWrData (fifoWrData),
  .fifoWrEn   (fifoWrEn),
  .fifoFull   (fifoFull),
  .overflow   (overflow)
);

// File: tb/sim_evts_stamp_top.sv
`timescale 1ns/1ps
module sim_evts_stamp_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pulseIn = 1'b0;
  logic        fifoFull = 1'b0;
  logic [31:0] wrData;
  logic        wrEn;
  logic        ovf;
  logic [15:0] wrDataS;
  logic        wrEnS;
  logic        ovfS;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int expSeq = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  evts_stamp_top u0 (
    .clk(clk), .rst(rst), .pulseIn(pulseIn), .fifoWrData(wrData),
    .fifoWrEn(wrEn), .fifoFull(fifoFull), .overflow(ovf)
  );

  // narrow time field so the time wrap is reachable
  evts_stamp_top #(.TIME_W(8)) u1 (
    .clk(clk), .rst(rst), .pulseIn(pulseIn), .fifoWrData(wrDataS),
    .fifoWrEn(wrEnS), .fifoFull(fifoFull), .overflow(ovfS)
  );

  // {width[31:24], gap[23:16], full[15:8], expected write[7:0]}
  localparam logic [31:0] VEC [0:7] = '{
    32'h03_04_00_01, 32'h01_03_00_01, 32'h14_05_00_01, 32'h02_02_00_01,
    32'h03_04_01_00, 32'h03_04_01_00, 32'h05_03_00_01, 32'h01_01_00_01
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one event: pulse of given width, optional full over the detect cycle
  task automatic runEvent(input int width, input int gap, input bit full, input bit expWr);
    int n0;
    int writes;
    int writesS;
    logic [31:0] expWord;
    n0 = cyc;
    writes = 0;
    writesS = 0;
    expWord = {expSeq[7:0], 24'(n0 + 2)};
    for (int i = 0; i < ((width > 4) ? width : 4) + 2; i++) begin
      pulseIn  = (i < width);
      fifoFull = full && (i < 3);
      @(negedge clk);
      if (wrEn) writes++;
      if (wrEnS) writesS++;
      if (i == 2) begin
        chk(wrEn == expWr, "R4/R7 write strobe timing", {31'd0, wrEn}, {31'd0, expWr});
        if (expWr) begin
          chk(wrData == expWord, "R3/R4/R5 word", wrData, expWord);
          chk(wrDataS == {expSeq[7:0], 8'(n0 + 2)}, "R6 narrow time wrap",
              {16'd0, wrDataS}, {16'd0, expSeq[7:0], 8'(n0 + 2)});
        end
        if (full) chk(ovf == 1'b1, "R8 overflow set", {31'd0, ovf}, 32'd1);
      end
    end
    chk(writes == int'(expWr), "R2 one write per pulse", writes, {31'd0, expWr});
    chk(writesS == int'(expWr), "R2 one write per pulse narrow", writesS, {31'd0, expWr});
    pulseIn  = 1'b0;
    fifoFull = 1'b0;
    expSeq = (expSeq + 1) % 256;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wrEn == 0 && ovf == 0 && wrData == 0, "R1 reset outputs", {wrData[29:0], wrEn, ovf}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(wrEn == 0 && ovf == 0 && wrData == 0, "R1 after release", {wrData[29:0], wrEn, ovf}, 32'd0);
    repeat (3) @(negedge clk);

    // vector table
    for (int v = 0; v < 8; v++) begin
      if (v == 4) chk(ovf == 1'b0, "R8 overflow clear before drop", {31'd0, ovf}, 32'd0);
      runEvent(int'(VEC[v][31:24]), int'(VEC[v][23:16]), VEC[v][8], VEC[v][0]);
    end
    chk(ovf == 1'b1, "R8 overflow sticky", {31'd0, ovf}, 32'd1);

    // sequence wrap (R5) and narrow time wrap (R6)
    for (int k = 0; k < 262; k++) runEvent(2, 2, 1'b0, 1'b1);
    chk(expSeq < 20, "R5 sequence wrapped", expSeq, 32'd0);
    chk(ovf == 1'b1, "R8 overflow still set", {31'd0, ovf}, 32'd1);

    // mid-run reset (R9)
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    expSeq = 0;
    @(negedge clk);
    chk(ovf == 1'b0, "R9 reset clears overflow", {31'd0, ovf}, 32'd0);
    runEvent(3, 3, 1'b0, 1'b1);
    runEvent(1, 3, 1'b1, 1'b0);
    runEvent(4, 3, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule